// File: doc/BRIEF.md
# Serial Block-Write Control Register Slave

This block is a two-wire serial bus slave that lets a bus master load a small bank of 8-bit control registers. The serial clock and data lines are brought into the block's own clock domain through a short synchronizer. Start and stop conditions are detected there, and the slave then follows one fixed write framing. First comes an address byte. If the byte carries the slave's 7-bit address with a write direction bit, the slave acknowledges it. A command byte follows, then a byte count. After those, the data bytes land in consecutive registers beginning at index 0.

The data line is open-drain. The block never drives it high. It only asserts `sda_low_o`, which the pad turns into a pull to ground during an acknowledge slot. The register bank holds two output-enable registers, where a 1 bit enables the matching output and a 0 disables it, and one test register. The test register's bit 7 selects the leakage test mode when 0 and normal operation when 1. Each register leaves reset with its own fixed value.

Top module: `smb_ctl_slave`

## Requirements
- R1: After reset, register 0 (`reg_bank_o[7:0]`) reads 0xFF, register 1 (`reg_bank_o[15:8]`) reads 0xC0 and register 2 (`reg_bank_o[23:16]`) reads 0xC0.
- R2: A start condition is SDA falling while SCL is high. A stop condition is SDA rising while SCL is high. SDA changes while SCL is low are ordinary data.
- R3: The first byte after a start is sent MSB first. It carries the address in bits 7:1 and the direction in bit 0. Only an address equal to `DEV_ADDR` with bit 0 equal to 0 is acknowledged. Any other first byte leaves SDA released for the whole frame and changes no register.
- R4: `sda_low_o` is asserted only in the acknowledge slot. It rises on the SCL falling edge after the 8th bit of a byte and drops on the SCL falling edge after the 9th bit. It never changes while SCL is high.
- R5: After an acknowledged address, the slave acknowledges a command byte, whose value is ignored, then a byte count byte, then every data byte.
- R6: Data bytes are received MSB first and written to register 0, 1, 2 in arrival order. Each write takes effect when the byte's 8th bit completes.
- R7: Writes stop at the smaller of the byte count and `NUM_REGS`. Bytes beyond that limit are still acknowledged but discarded, and a count of 0 writes nothing.
- R8: A stop or a repeated start at any bit position ends the current frame and releases SDA. A partly received byte is never written, and after a repeated start the next byte is treated as an address byte.
- R9: A register keeps its value across frames until a later data byte is written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Resolved level of the serial data line |
| sda_low_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| reg_bank_o | output | NUM_REGS*8 | Register contents, register k at bits 8k+7:8k |

## Verification
The hardest situation to bring about is a frame cut off in the middle of a byte. This happens when a stop or repeated start arrives after only a few bits of a data byte, while the write index sits just below or at the count limit. A partial shift must then be dropped and the frame restarted cleanly. The stimulus reaches this state by truncating random frames after a random number of bits and ending them either with a stop or with a repeated start that opens the next frame. Counts above and below the register number, including 0, are drawn so the discard path is also exercised.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_COUNT,
    ST_DATA,
    ST_SKIP
  } frame_st_t;

  // Address byte hits when upper seven bits match and direction bit is write.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return (b[7:1] == dev) && !b[0];
  endfunction

  // Number of data bytes that may land in the bank.
  function automatic logic [7:0] write_limit(input logic [7:0] cnt, input int nregs);
    logic [7:0] n8;
    n8 = nregs[7:0];
    return (cnt < n8) ? cnt : n8;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];
  assign scl_d = scl_pipe[STAGES];
  assign sda_d = sda_pipe[STAGES];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_frame_fsm.sv
module smb_frame_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_evt,
  input  logic       stop_evt,
  output logic       sda_low,
  output logic       ack_slot,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data
);
  frame_st_t  state_q;
  logic [3:0] bitcnt_q;
  logic [7:0] shreg_q;
  logic [7:0] limit_q;
  logic [7:0] widx_q;
  logic       byte_done;

  assign byte_done = scl_fall && (bitcnt_q == 4'd8) && (state_q != ST_IDLE)
                     && !start_evt && !stop_evt;
  assign ack_slot  = (bitcnt_q >= 4'd8);
  assign wr_en     = byte_done && (state_q == ST_DATA) && (widx_q < limit_q);
  assign wr_idx    = widx_q;
  assign wr_data   = shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      limit_q  <= '0;
      widx_q   <= '0;
      sda_low  <= 1'b0;
    end else if (start_evt) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      sda_low  <= 1'b0;
    end else if (stop_evt) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      sda_low  <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise && bitcnt_q < 4'd9) begin
        if (bitcnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_s};
        bitcnt_q <= bitcnt_q + 4'd1;
      end else if (byte_done) begin
        unique case (state_q)
          ST_ADDR: begin
            if (addr_hit(shreg_q, DEV_ADDR)) begin
              sda_low <= 1'b1;
              state_q <= ST_CMD;
            end else begin
              state_q <= ST_SKIP;
            end
          end
          ST_CMD: begin
            sda_low <= 1'b1;
            state_q <= ST_COUNT;
          end
          ST_COUNT: begin
            sda_low <= 1'b1;
            limit_q <= write_limit(shreg_q, NUM_REGS);
            widx_q  <= '0;
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            sda_low <= 1'b1;
            if (widx_q != 8'hFF) widx_q <= widx_q + 8'd1;
          end
          default: ;
        endcase
      end else if (scl_fall && bitcnt_q == 4'd9) begin
        sda_low  <= 1'b0;
        bitcnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int                    NUM_REGS   = 3,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS = 24'hC0C0FF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= RESET_VALS[g*8 +: 8];
      else if (wr_en && wr_idx == 8'(g)) r_q <= wr_data;
    end
    assign regs_o[g*8 +: 8] = r_q;
  end
endmodule

// File: rtl/smb_ctl_slave.sv
module smb_ctl_slave #(
  parameter logic [6:0]            DEV_ADDR   = 7'h69,
  parameter int                    NUM_REGS   = 3,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS = 24'hC0C0FF,
  parameter int                    SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_low_o,
  output logic [NUM_REGS*8-1:0] reg_bank_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic ack_slot, wr_en;
  logic [7:0] wr_idx, wr_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_frame_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_low(sda_low_o), .ack_slot(ack_slot), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  smb_reg_bank #(.NUM_REGS(NUM_REGS), .RESET_VALS(RESET_VALS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(reg_bank_o)
  );
endmodule

// File: rtl/smb_ctl_checker.sv
module smb_ctl_checker #(
  parameter int                    NUM_REGS   = 3,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS = 24'hC0C0FF
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  ack_slot,
  input logic                  wr_en,
  input logic [7:0]            wr_idx,
  input logic                  sda_low_o,
  input logic [NUM_REGS*8-1:0] reg_bank_o
);
  assert_reset_vals_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> reg_bank_o == RESET_VALS);

  assert_ack_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_o |-> ack_slot);

  assert_ack_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_low_o));

  assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sda_low_o);

  assert_write_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx < 8'(NUM_REGS));

  assert_write_on_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_bank_o) |-> $past(wr_en));
endmodule

bind smb_ctl_slave smb_ctl_checker #(.NUM_REGS(NUM_REGS), .RESET_VALS(RESET_VALS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .ack_slot(ack_slot), .wr_en(wr_en), .wr_idx(wr_idx),
  .sda_low_o(sda_low_o), .reg_bank_o(reg_bank_o)
);

// File: tb/test_smb_ctl_slave.sv
module test_smb_ctl_slave;
  localparam logic [6:0] DEV = 7'h69;
  localparam int NR = 3;

  logic clk = 0, rst_n = 0;
  logic scl = 1, m_sda = 1;
  logic sda_low;
  logic [NR*8-1:0] regs;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_low;

  always #2 clk = ~clk;

  smb_ctl_slave #(.DEV_ADDR(DEV), .NUM_REGS(NR)) i_smb_ctl_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_low_o(sda_low), .reg_bank_o(regs)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_r [NR];
  logic [7:0] dbuf [8];
  bit busy = 0;

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lim(input logic [7:0] c);
    return (c > 8'(NR)) ? 8'(NR) : c;
  endfunction

  task automatic bit_out(input logic b, input bit check_rel);
    m_sda = b; wclk(6);
    scl = 1; wclk(4);
    if (check_rel) chk(sda_bus == b, "R4 released", sda_bus, b);
    wclk(4);
    scl = 0; wclk(6);
  endtask

  task automatic ack_in(output logic ack);
    m_sda = 1; wclk(6);
    scl = 1; wclk(4);
    ack = !sda_bus;
    wclk(4);
    scl = 0; wclk(6);
  endtask

  task automatic byte_out(input logic [7:0] b, input bit exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i], i == 7);
    ack_in(a);
    chk(a == exp_ack, req, a, exp_ack);
  endtask

  task automatic cond_start;
    if (busy) begin
      m_sda = 1; wclk(6); scl = 1; wclk(6);
    end else begin
      m_sda = 1; scl = 1; wclk(6);
    end
    m_sda = 0; wclk(6);
    scl = 0; wclk(6);
    busy = 1;
  endtask

  task automatic cond_stop;
    m_sda = 0; wclk(6);
    scl = 1; wclk(6);
    m_sda = 1; wclk(8);
    busy = 0;
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++)
      chk(regs[i*8 +: 8] == exp_r[i], req, regs[i*8 +: 8], exp_r[i]);
  endtask

  // cut_bits > 0: send that many bits of a further byte, then end with
  // stop (cut_rs=0) or leave the bus for a repeated start (cut_rs=1).
  task automatic frame(input logic [6:0] a, input bit rw, input logic [7:0] cnt,
                       input int nb, input int cut_bits, input bit cut_rs);
    bit ok;
    ok = (a == DEV) && !rw;
    cond_start;
    byte_out({a, rw}, ok, "R3 address ack");
    byte_out(8'($urandom), ok, "R5 command ack");
    byte_out(cnt, ok, "R5 count ack");
    for (int i = 0; i < nb; i++) begin
      byte_out(dbuf[i], ok, "R7 data ack");
      if (ok && 8'(i) < lim(cnt)) exp_r[i] = dbuf[i];
    end
    if (cut_bits > 0) begin
      for (int i = 0; i < cut_bits; i++) bit_out(1'b1, 1'b0);
      if (!cut_rs) cond_stop;
    end else begin
      cond_stop;
    end
    check_regs(ok ? "R6 written" : "R3 unchanged");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    exp_r[0] = 8'hFF; exp_r[1] = 8'hC0; exp_r[2] = 8'hC0;
    wclk(5); rst_n = 1; wclk(5);
    check_regs("R1 reset");
    chk(sda_low == 0, "R4 idle", sda_low, 0);

    // R2: SDA toggles while SCL low are data, not conditions
    scl = 0; wclk(4); m_sda = 0; wclk(4); m_sda = 1; wclk(4);
    chk(sda_low == 0, "R2 no start", sda_low, 0);

    // R5/R6: exact count
    dbuf[0] = 8'h12; dbuf[1] = 8'h34; dbuf[2] = 8'h56;
    frame(DEV, 0, 8'd3, 3, 0, 0);
    // R3: wrong address and read direction
    dbuf[0] = 8'hAA; dbuf[1] = 8'hBB;
    frame(DEV ^ 7'h01, 0, 8'd2, 2, 0, 0);
    frame(DEV, 1, 8'd2, 2, 0, 0);
    // R7: count 0, count beyond bank, count below bytes
    frame(DEV, 0, 8'd0, 2, 0, 0);
    dbuf[0] = 8'h01; dbuf[1] = 8'h02; dbuf[2] = 8'h03; dbuf[3] = 8'h04; dbuf[4] = 8'h05;
    frame(DEV, 0, 8'd5, 5, 0, 0);
    dbuf[0] = 8'h77; dbuf[1] = 8'h88; dbuf[2] = 8'h99;
    frame(DEV, 0, 8'd2, 3, 0, 0);
    // R8: partial byte then stop; partial byte then repeated start
    dbuf[0] = 8'h5A;
    frame(DEV, 0, 8'd3, 1, 5, 0);
    chk(sda_low == 0, "R8 stop release", sda_low, 0);
    dbuf[0] = 8'hC3;
    frame(DEV, 0, 8'd3, 1, 3, 1);
    dbuf[0] = 8'h3C; dbuf[1] = 8'h4D;
    frame(DEV, 0, 8'd2, 2, 0, 0);
    // R9: a frame writing only register 0 keeps the others
    dbuf[0] = 8'hE1;
    frame(DEV, 0, 8'd1, 1, 0, 0);
    check_regs("R9 hold");

    // random frames
    for (int k = 0; k < 30; k++) begin
      logic [6:0] a;
      int nb, cb;
      a  = ($urandom % 4 == 0) ? 7'($urandom) : DEV;
      nb = $urandom % 6;
      cb = ($urandom % 3 == 0) ? 1 + $urandom % 7 : 0;
      for (int i = 0; i < 8; i++) dbuf[i] = 8'($urandom);
      frame(a, ($urandom % 8) == 0, 8'($urandom % 6), nb, cb, $urandom % 2);
    end
    if (busy) cond_stop;
    check_regs("R8 final");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule